// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-style microcontroller core. Each issue presents an accumulator byte, a second operand byte (a source byte or the B register), the current carry and auxiliary-carry flags and a 5-bit operation code. The block returns a result byte for the accumulator, a second result byte for the operations that produce two bytes, new carry (CY), auxiliary-carry (AC) and overflow (OV) values, and one write enable per destination. The register file keeps its old flag or B value wherever an enable is low.

Every operation except divide is registered once and appears on the cycle after issue. Divide runs in a restoring divider that retires `DIV_BPC` quotient bits per clock and raises `out_valid` when the quotient and remainder are ready. The decoder in front of the block must not issue while a divide is in flight. An issue made in that window is dropped.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (add) sums A and B with cy_in ignored, and opcode 1 (add with carry) sums A, B and cy_in. CY is the carry out of bit 7, AC is the carry out of bit 3, and OV is set when the signed result does not fit in 8 bits. All three flag enables are high and b_we is low.
- R2: Opcode 2 computes A - B - cy_in. CY and AC are the borrows out of bit 7 and out of bit 3. OV is set when exactly one of bit 6 and bit 7 borrows. All three flag enables are high.
- R3: Opcode 3 returns A+1 and opcode 4 returns A-1, both wrapping modulo 256 (FFH+1 = 00H, 00H-1 = FFH). No flag enable and no b_we is raised.
- R4: Opcodes 5, 6 and 7 return A AND B, A OR B and A XOR B. Opcode 8 returns 00H and opcode 9 returns NOT A. None of them raises a flag enable.
- R5: Opcode 10 rotates A left and opcode 12 rotates A right, each by one bit. Opcode 14 exchanges the two nibbles of A. None of these raises a flag enable. Opcode 11 rotates left through carry: bit 7 goes to CY and cy_in goes to bit 0. Opcode 13 rotates right through carry: bit 0 goes to CY and cy_in goes to bit 7. Both raise only cy_we.
- R6: Opcode 15 (decimal adjust) first adds 06H if the low nibble exceeds 9 or ac_in is set. It then adds 60H if the high nibble exceeds 9 or the carry is set. CY is set by that high correction or by a carry out of the low correction, and an incoming CY is never cleared. Only cy_we is raised.
- R7: Opcode 16 multiplies A by B as unsigned values. The low byte of the product goes to res_a and the high byte to res_b. OV is set when the product exceeds FFH and CY is cleared. cy_we, ov_we and b_we are high and ac_we is low.
- R8: Opcode 17 divides A by a nonzero B as unsigned values. The quotient goes to res_a and the remainder to res_b, with CY and OV cleared. cy_we, ov_we and b_we are high.
- R9: Opcode 17 with B = 00H sets OV and clears CY, with the same enables as R8. res_a and res_b carry no defined value.
- R10: Opcodes 18 to 31 return A unchanged with every enable low.
- R11: For every opcode except 17, out_valid rises on the cycle after the issuing clock edge. For opcode 17 it rises 8/DIV_BPC cycles later than that.
- R12: From the edge that accepts a divide until the edge that presents its result, further issues are dropped and produce no result.
- R13: During reset and after reset, until the first issue, out_valid and all write enables are low. Whenever out_valid is low, every enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the operands and opcode |
| op_code | input | 5 | Operation select |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand or B register |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| out_valid | output | 1 | Result strobe, one cycle per accepted issue |
| res_a | output | 8 | Result byte for the accumulator |
| res_b | output | 8 | Result byte for B (multiply high byte or remainder) |
| b_we | output | 1 | Write enable for res_b |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| ov_out | output | 1 | New overflow flag |
| cy_we | output | 1 | Carry write enable |
| ac_we | output | 1 | Auxiliary-carry write enable |
| ov_we | output | 1 | Overflow write enable |

## Verification
The bench builds two copies side by side. One has DIV_BPC = 1, so a divide takes eight stepping cycles. The other has DIV_BPC = 4, which unrolls four subtract-and-shift stages into each cycle and finishes in two. Both copies receive the same issues, so the single-bit and the chained divider paths are held to the same quotients, remainders and zero-divisor flags. The latency check and the drop-while-busy check then cover both a long busy window and a short one.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_CLR  = 5'd8,
        OP_CPL  = 5'd9,
        OP_RL   = 5'd10,
        OP_RLC  = 5'd11,
        OP_RR   = 5'd12,
        OP_RRC  = 5'd13,
        OP_SWAP = 5'd14,
        OP_DA   = 5'd15,
        OP_MUL  = 5'd16,
        OP_DIV  = 5'd17
    } alu_op_e;

    typedef struct packed {
        byte_t a;
        byte_t b;
        logic  cy;
        logic  ac;
        logic  ov;
        logic  cy_we;
        logic  ac_we;
        logic  ov_we;
        logic  b_we;
    } alu_res_t;

    function automatic logic nib_over9(input logic [NW-1:0] n);
        return n > NW'(9);
    endfunction

    function automatic alu_res_t res_plain(input byte_t a);
        alu_res_t r;
        r       = '0;
        r.a     = a;
        return r;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  byte_t a,
    input  byte_t b,
    input  logic  cy_in,
    input  logic  sub,
    input  logic  use_cy,
    output byte_t sum,
    output logic  cy,
    output logic  ac,
    output logic  ov
);
    logic          cin;
    logic          ci;
    byte_t         bx;
    logic [NW:0]   lo_s;
    logic [DW-1:0] mid_s;
    logic [DW:0]   full_s;

    // Subtraction is A + ~B + (1 - borrow); carries then read as inverted borrows.
    always_comb begin
        cin    = use_cy & cy_in;
        ci     = sub ? ~cin : cin;
        bx     = sub ? ~b : b;
        lo_s   = {1'b0, a[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, ci};
        mid_s  = {1'b0, a[DW-2:0]} + {1'b0, bx[DW-2:0]} + {{(DW-1){1'b0}}, ci};
        full_s = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, ci};
        sum    = full_s[DW-1:0];
        cy     = full_s[DW] ^ sub;
        ac     = lo_s[NW] ^ sub;
        ov     = full_s[DW] ^ mid_s[DW-1];
    end
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
(
    input  alu_op_e  op,
    input  byte_t    a,
    input  byte_t    b,
    input  logic     cy_in,
    input  logic     ac_in,
    output alu_res_t res
);
    logic          lo_fix;
    logic          hi_fix;
    logic          c_mid;
    logic [DW:0]   da_t;
    logic [DW:0]   da_u;
    logic [2*DW-1:0] prod;

    always_comb begin
        lo_fix = nib_over9(a[NW-1:0]) | ac_in;
        da_t   = {1'b0, a} + (lo_fix ? (DW+1)'(6) : '0);
        c_mid  = cy_in | da_t[DW];
        hi_fix = nib_over9(da_t[DW-1:NW]) | c_mid;
        da_u   = {1'b0, da_t[DW-1:0]} + (hi_fix ? (DW+1)'(8'h60) : '0);
        prod   = a * b;
    end

    always_comb begin
        res = res_plain(a);
        unique case (op)
            OP_INC:  res.a = a + 1'b1;
            OP_DEC:  res.a = a - 1'b1;
            OP_AND:  res.a = a & b;
            OP_OR:   res.a = a | b;
            OP_XOR:  res.a = a ^ b;
            OP_CLR:  res.a = '0;
            OP_CPL:  res.a = ~a;
            OP_RL:   res.a = {a[DW-2:0], a[DW-1]};
            OP_RR:   res.a = {a[0], a[DW-1:1]};
            OP_SWAP: res.a = {a[NW-1:0], a[DW-1:NW]};
            OP_RLC: begin
                res.a     = {a[DW-2:0], cy_in};
                res.cy    = a[DW-1];
                res.cy_we = 1'b1;
            end
            OP_RRC: begin
                res.a     = {cy_in, a[DW-1:1]};
                res.cy    = a[0];
                res.cy_we = 1'b1;
            end
            OP_DA: begin
                res.a     = da_u[DW-1:0];
                res.cy    = c_mid | hi_fix | da_u[DW];
                res.cy_we = 1'b1;
            end
            OP_MUL: begin
                res.a     = prod[DW-1:0];
                res.b     = prod[2*DW-1:DW];
                res.cy    = 1'b0;
                res.ov    = |prod[2*DW-1:DW];
                res.cy_we = 1'b1;
                res.ov_we = 1'b1;
                res.b_we  = 1'b1;
            end
            default: res = res_plain(a);
        endcase
    end
endmodule

// File: rtl/alu8_div.sv
module alu8_div
    import alu8_pkg::*;
#(
    parameter int DIV_BPC = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  byte_t dividend,
    input  byte_t divisor,
    output logic  busy,
    output logic  done,
    output logic  zero_div,
    output byte_t quot,
    output byte_t rem
);
    localparam int STEPS = DW / DIV_BPC;
    localparam int CW    = $clog2(STEPS + 1);

    byte_t         q_r;
    byte_t         r_r;
    byte_t         d_r;
    logic [CW-1:0] cnt_r;
    logic          busy_r;
    logic          done_r;
    logic          dz_r;

    byte_t       q_n;
    logic [DW:0] r_n;
    logic [DW:0] tmp;

    // DIV_BPC restoring steps chained per clock.
    always_comb begin
        q_n = q_r;
        r_n = {1'b0, r_r};
        tmp = '0;
        for (int i = 0; i < DIV_BPC; i++) begin
            tmp = {r_n[DW-1:0], q_n[DW-1]};
            q_n = {q_n[DW-2:0], 1'b0};
            if (tmp >= {1'b0, d_r}) begin
                r_n    = tmp - {1'b0, d_r};
                q_n[0] = 1'b1;
            end else begin
                r_n = tmp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r    <= '0;
            r_r    <= '0;
            d_r    <= '0;
            cnt_r  <= '0;
            busy_r <= 1'b0;
            done_r <= 1'b0;
            dz_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (start) begin
                q_r    <= dividend;
                r_r    <= '0;
                d_r    <= divisor;
                cnt_r  <= CW'(STEPS);
                busy_r <= 1'b1;
                dz_r   <= (divisor == '0);
            end else if (busy_r) begin
                q_r   <= q_n;
                r_r   <= r_n[DW-1:0];
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CW'(1)) begin
                    busy_r <= 1'b0;
                    done_r <= 1'b1;
                end
            end
        end
    end

    assign busy     = busy_r;
    assign done     = done_r;
    assign zero_div = dz_r;
    assign quot     = q_r;
    assign rem      = r_r;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DIV_BPC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPW-1:0]   op_code,
    input  logic [DW-1:0]    a_in,
    input  logic [DW-1:0]    b_in,
    input  logic             cy_in,
    input  logic             ac_in,
    output logic             out_valid,
    output logic [DW-1:0]    res_a,
    output logic [DW-1:0]    res_b,
    output logic             b_we,
    output logic             cy_out,
    output logic             ac_out,
    output logic             ov_out,
    output logic             cy_we,
    output logic             ac_we,
    output logic             ov_we
);
    alu_op_e  op_e;
    logic     div_busy;
    logic     div_done;
    logic     div_zero;
    byte_t    div_q;
    byte_t    div_r;
    logic     accept;
    logic     div_go;
    logic     is_arith;

    byte_t    as_sum;
    logic     as_cy, as_ac, as_ov;
    alu_res_t unit_res;
    alu_res_t nxt;
    alu_res_t res_q;
    alu_res_t shown;
    logic     valid_q;

    assign op_e     = alu_op_e'(op_code);
    assign accept   = in_valid && !div_busy;
    assign div_go   = accept && (op_e == OP_DIV);
    assign is_arith = (op_e == OP_ADD) || (op_e == OP_ADDC) || (op_e == OP_SUBB);

    alu8_addsub u_addsub (
        .a      (a_in),
        .b      (b_in),
        .cy_in  (cy_in),
        .sub    (op_e == OP_SUBB),
        .use_cy (op_e != OP_ADD),
        .sum    (as_sum),
        .cy     (as_cy),
        .ac     (as_ac),
        .ov     (as_ov)
    );

    alu8_unit u_unit (
        .op    (op_e),
        .a     (a_in),
        .b     (b_in),
        .cy_in (cy_in),
        .ac_in (ac_in),
        .res   (unit_res)
    );

    alu8_div #(.DIV_BPC(DIV_BPC)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_go),
        .dividend (a_in),
        .divisor  (b_in),
        .busy     (div_busy),
        .done     (div_done),
        .zero_div (div_zero),
        .quot     (div_q),
        .rem      (div_r)
    );

    always_comb begin
        nxt = unit_res;
        if (is_arith) begin
            nxt       = res_plain(as_sum);
            nxt.cy    = as_cy;
            nxt.ac    = as_ac;
            nxt.ov    = as_ov;
            nxt.cy_we = 1'b1;
            nxt.ac_we = 1'b1;
            nxt.ov_we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= accept && (op_e != OP_DIV);
            if (accept) begin
                res_q <= nxt;
            end
        end
    end

    always_comb begin
        shown = '0;
        if (div_done) begin
            shown.a     = div_q;
            shown.b     = div_r;
            shown.cy    = 1'b0;
            shown.ov    = div_zero;
            shown.cy_we = 1'b1;
            shown.ov_we = 1'b1;
            shown.b_we  = 1'b1;
        end else if (valid_q) begin
            shown = res_q;
        end
    end

    assign out_valid = valid_q | div_done;
    assign res_a     = shown.a;
    assign res_b     = shown.b;
    assign b_we      = shown.b_we;
    assign cy_out    = shown.cy;
    assign ac_out    = shown.ac;
    assign ov_out    = shown.ov;
    assign cy_we     = shown.cy_we;
    assign ac_we     = shown.ac_we;
    assign ov_we     = shown.ov_we;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [OPW-1:0] op_code,
    input logic           out_valid,
    input logic           b_we,
    input logic           cy_out,
    input logic           cy_we,
    input logic           ac_we,
    input logic           ov_we,
    input logic           div_busy,
    input logic           div_done,
    input logic           valid_q
);
    AST_IDLE_NO_WRITES: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(cy_we || ac_we || ov_we || b_we)); // R13

    AST_AC_ONLY_ARITH: assert property (@(posedge clk) disable iff (rst)
        ac_we |-> (cy_we && ov_we && !b_we)); // R1

    AST_PAIR_CLEARS_CY: assert property (@(posedge clk) disable iff (rst)
        b_we |-> (cy_we && ov_we && !ac_we && !cy_out)); // R7

    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !div_busy && op_code != OP_DIV) |=> (out_valid && !div_done)); // R11

    AST_DIV_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !div_busy && op_code == OP_DIV) |=> !out_valid); // R11

    AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && div_busy) |=> !valid_q); // R12

    AST_NO_DOUBLE_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(valid_q && div_done)); // R12
endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .out_valid (out_valid),
    .b_we      (b_we),
    .cy_out    (cy_out),
    .cy_we     (cy_we),
    .ac_we     (ac_we),
    .ov_we     (ov_we),
    .div_busy  (div_busy),
    .div_done  (div_done),
    .valid_q   (valid_q)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       cy;
        logic       ac;
        logic [7:0] ea;
        logic [7:0] eb;
        logic       ecy;
        logic       eac;
        logic       eov;
        logic [3:0] ewe;   // {cy_we, ac_we, ov_we, b_we}
        logic       chk_ab;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{5'd0,  8'h7F, 8'h01, 1'b1, 1'b0, 8'h80, 8'h00, 1'b0, 1'b1, 1'b1, 4'b1110, 1'b1},
        '{5'd1,  8'hFF, 8'h01, 1'b1, 1'b0, 8'h01, 8'h00, 1'b1, 1'b1, 1'b0, 4'b1110, 1'b1},
        '{5'd2,  8'hC9, 8'h54, 1'b1, 1'b0, 8'h74, 8'h00, 1'b0, 1'b0, 1'b1, 4'b1110, 1'b1},
        '{5'd2,  8'h00, 8'h01, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 4'b1110, 1'b1},
        '{5'd3,  8'hFF, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd4,  8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd5,  8'hD3, 8'h75, 1'b1, 1'b1, 8'h51, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd6,  8'hD3, 8'h75, 1'b1, 1'b1, 8'hF7, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd7,  8'hC3, 8'hAA, 1'b1, 1'b1, 8'h69, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd8,  8'hC3, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd9,  8'hC3, 8'h00, 1'b1, 1'b1, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd10, 8'hC3, 8'h00, 1'b0, 1'b0, 8'h87, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd11, 8'hC3, 8'h00, 1'b1, 1'b0, 8'h87, 8'h00, 1'b1, 1'b0, 1'b0, 4'b1000, 1'b1},
        '{5'd12, 8'hC3, 8'h00, 1'b0, 1'b0, 8'hE1, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd13, 8'hC3, 8'h00, 1'b0, 1'b0, 8'h61, 8'h00, 1'b1, 1'b0, 1'b0, 4'b1000, 1'b1},
        '{5'd14, 8'hC3, 8'h00, 1'b1, 1'b1, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd15, 8'h81, 8'h00, 1'b0, 1'b1, 8'h87, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b1},
        '{5'd15, 8'hA5, 8'h00, 1'b0, 1'b0, 8'h05, 8'h00, 1'b1, 1'b0, 1'b0, 4'b1000, 1'b1},
        '{5'd15, 8'h12, 8'h00, 1'b1, 1'b0, 8'h72, 8'h00, 1'b1, 1'b0, 1'b0, 4'b1000, 1'b1},
        '{5'd15, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'b1000, 1'b1},
        '{5'd16, 8'h55, 8'h17, 1'b1, 1'b0, 8'hA3, 8'h07, 1'b0, 1'b0, 1'b1, 4'b1011, 1'b1},
        '{5'd16, 8'h0F, 8'h11, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1011, 1'b1},
        '{5'd17, 8'h5A, 8'h05, 1'b1, 1'b0, 8'h12, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1011, 1'b1},
        '{5'd17, 8'hFF, 8'h10, 1'b1, 1'b0, 8'h0F, 8'h0F, 1'b0, 1'b0, 1'b0, 4'b1011, 1'b1},
        '{5'd17, 8'h07, 8'h09, 1'b0, 1'b0, 8'h00, 8'h07, 1'b0, 1'b0, 1'b0, 4'b1011, 1'b1},
        '{5'd17, 8'h3C, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'b1011, 1'b0},
        '{5'd31, 8'h5A, 8'h33, 1'b1, 1'b1, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
        '{5'd0,  8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 4'b1110, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] a_in = '0;
    logic [7:0] b_in = '0;
    logic       cy_in = 1'b0;
    logic       ac_in = 1'b0;

    logic       o_valid [2];
    logic [7:0] o_a [2];
    logic [7:0] o_b [2];
    logic       o_bwe [2];
    logic       o_cy [2];
    logic       o_ac [2];
    logic       o_ov [2];
    logic       o_cywe [2];
    logic       o_acwe [2];
    logic       o_ovwe [2];

    logic [7:0] cap_a [2];
    logic [7:0] cap_b [2];
    logic [2:0] cap_f [2];
    logic [3:0] cap_we [2];
    int         lat [2];

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    vec_t v;
    int   pulses [2];

    always #2 clk = ~clk;

    alu8_core #(.DIV_BPC(1)) u_alu8_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .a_in(a_in), .b_in(b_in), .cy_in(cy_in), .ac_in(ac_in),
        .out_valid(o_valid[0]), .res_a(o_a[0]), .res_b(o_b[0]), .b_we(o_bwe[0]),
        .cy_out(o_cy[0]), .ac_out(o_ac[0]), .ov_out(o_ov[0]),
        .cy_we(o_cywe[0]), .ac_we(o_acwe[0]), .ov_we(o_ovwe[0])
    );

    alu8_core #(.DIV_BPC(4)) u_alu8_core_q4 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .a_in(a_in), .b_in(b_in), .cy_in(cy_in), .ac_in(ac_in),
        .out_valid(o_valid[1]), .res_a(o_a[1]), .res_b(o_b[1]), .b_we(o_bwe[1]),
        .cy_out(o_cy[1]), .ac_out(o_ac[1]), .ov_out(o_ov[1]),
        .cy_we(o_cywe[1]), .ac_we(o_acwe[1]), .ov_we(o_ovwe[1])
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [4:0] op, input logic [7:0] b);
        case (op)
            5'd0, 5'd1:                      return "R1";
            5'd2:                            return "R2";
            5'd3, 5'd4:                      return "R3";
            5'd5, 5'd6, 5'd7, 5'd8, 5'd9:    return "R4";
            5'd10, 5'd11, 5'd12, 5'd13, 5'd14: return "R5";
            5'd15:                           return "R6";
            5'd16:                           return "R7";
            5'd17:                           return (b == 8'h00) ? "R9" : "R8";
            default:                         return "R10";
        endcase
    endfunction

    task automatic grab(input int k, input int t);
        lat[k]    = t;
        cap_a[k]  = o_a[k];
        cap_b[k]  = o_b[k];
        cap_f[k]  = {o_cy[k], o_ac[k], o_ov[k]};
        cap_we[k] = {o_cywe[k], o_acwe[k], o_ovwe[k], o_bwe[k]};
    endtask

    task automatic issue(input vec_t x);
        @(negedge clk);
        op_code  = x.op;
        a_in     = x.a;
        b_in     = x.b;
        cy_in    = x.cy;
        ac_in    = x.ac;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat[0] = -1;
        lat[1] = -1;
        for (int t = 1; t <= 20; t++) begin
            for (int k = 0; k < 2; k++) begin
                if (lat[k] < 0 && o_valid[k]) grab(k, t);
            end
            if (lat[0] >= 0 && lat[1] >= 0) break;
            @(negedge clk);
        end
    endtask

    task automatic judge(input vec_t x, input int k);
        string r;
        int    steps;
        r     = req_of(x.op, x.b);
        steps = (k == 0) ? 8 : 2;
        // R11: one cycle, or one plus the divide steps
        chk("R11", $sformatf("latency inst%0d op%0d", k, x.op), lat[k],
            (x.op == 5'd17) ? steps + 1 : 1);
        chk(r, $sformatf("enables inst%0d op%0d", k, x.op), cap_we[k], x.ewe);
        if (x.chk_ab)
            chk(r, $sformatf("res_a inst%0d op%0d a=%0h b=%0h", k, x.op, x.a, x.b), cap_a[k], x.ea);
        if (x.chk_ab && x.ewe[0])
            chk(r, $sformatf("res_b inst%0d op%0d", k, x.op), cap_b[k], x.eb);
        if (x.ewe[3])
            chk(r, $sformatf("cy inst%0d op%0d a=%0h", k, x.op, x.a), cap_f[k][2], x.ecy);
        if (x.ewe[2])
            chk(r, $sformatf("ac inst%0d op%0d", k, x.op), cap_f[k][1], x.eac);
        if (x.ewe[1])
            chk(r, $sformatf("ov inst%0d op%0d", k, x.op), cap_f[k][0], x.eov);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: quiet during reset
        for (int k = 0; k < 2; k++)
            chk("R13", $sformatf("valid in reset inst%0d", k),
                {o_valid[k], o_cywe[k], o_acwe[k], o_ovwe[k], o_bwe[k]}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 2; k++)
            chk("R13", $sformatf("idle after reset inst%0d", k),
                {o_valid[k], o_cywe[k], o_acwe[k], o_ovwe[k], o_bwe[k]}, 0);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            issue(v);
            judge(v, 0);
            judge(v, 1);
        end

        // R12: an add offered one cycle after a divide is dropped
        @(negedge clk);
        op_code = 5'd17; a_in = 8'h5A; b_in = 8'h05; cy_in = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        op_code = 5'd0;  a_in = 8'h01; b_in = 8'h01; cy_in = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        pulses[0] = 0;
        pulses[1] = 0;
        for (int t = 0; t < 15; t++) begin
            for (int k = 0; k < 2; k++) begin
                if (o_valid[k]) begin
                    pulses[k]++;
                    chk("R12", $sformatf("result during drop inst%0d", k), o_a[k], 8'h12);
                end
            end
            @(negedge clk);
        end
        for (int k = 0; k < 2; k++)
            chk("R12", $sformatf("result count inst%0d", k), pulses[k], 1);

        // R13: enables low once idle again
        for (int k = 0; k < 2; k++)
            chk("R13", $sformatf("idle at end inst%0d", k),
                {o_valid[k], o_cywe[k], o_acwe[k], o_ovwe[k], o_bwe[k]}, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule